// File: doc/BRIEF.md
# Floating-Point Register Move Unit

This unit decodes and runs one family of 16-bit instruction words that move floating-point data. The data can go between floating-point registers, or between floating-point registers and a 32-bit memory port. The unit holds sixteen 32-bit floating-point registers and sixteen 32-bit general registers. The general registers supply addresses: plain indirect, post-increment, pre-decrement, or the sum of R0 and a second register. After reset, general register k holds `GR_BASE + k*GR_STEP` and every floating-point register holds zero. Software sees the floating-point file only through loads and stores on the memory port.

A mode input that is sampled with each strobe selects the transfer size. In single mode one 32-bit register moves in one cycle. In paired mode an even/odd register pair moves in two cycles, and the pointer step grows from 4 to 8 bytes. All memory traffic is combinational from the current instruction. Load data is taken from the read port in the same cycle the address is driven.

Top module: `fpmv_unit`

## Requirements
- R1: After reset, busy, done, illegal and mem_we are 0 and mem_addr is 0 when nothing executes. General register k holds GR_BASE + k*GR_STEP and every floating-point register holds 0.
- R2: A word is in the family only if bits [15:12] are 1111. Bits [11:8] name register n and bits [7:4] name register m. Low nibble 1100 is a register move, 1010 a store to [Rn], 1000 a load from [Rm], 1001 a post-increment load, 1011 a pre-decrement store, 0110 a load from [R0+Rm] and 0111 a store to [R0+Rn]. Any other strobed word raises illegal for that cycle and changes no state.
- R3: A register move copies FR m to FR n, with no memory access.
- R4: An indirect load drives mem_addr = Rm and writes mem_rdata of that same cycle into FR n.
- R5: A store drives FR m on mem_wdata with mem_we high for exactly one cycle per 32-bit word. An indirect store uses address Rn.
- R6: A post-increment load uses the original Rm as its address, then adds 4 (single) or 8 (paired) to Rm.
- R7: A pre-decrement store first subtracts 4 (single) or 8 (paired) from Rn, then uses the new value as its address.
- R8: Indexed forms use R0+Rm (load) or R0+Rn (store) as the address and change no general register.
- R9: In paired mode a transfer takes two cycles. The even register uses the first address and the odd register uses the first address + 4; a move copies both halves. busy is high only in the second cycle.
- R10: In paired mode, a strobed word whose destination field (load or move, bit 8) or source field (store or move, bit 4) is odd raises illegal and changes no state.
- R11: A strobe while busy is high is ignored.
- R12: done is high only in the final cycle of each executed instruction. illegal lasts one cycle and never coincides with done, busy or mem_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_vld | input | 1 | Instruction strobe |
| instr | input | 16 | Instruction word |
| pair_mode | input | 1 | 1 = paired 64-bit transfers |
| mem_addr | output | 32 | Memory byte address, 0 when no access |
| mem_wdata | output | 32 | Store data, 0 when not writing |
| mem_we | output | 1 | Write enable, one cycle per word |
| mem_rdata | input | 32 | Read data for the address in the same cycle |
| busy | output | 1 | Second cycle of a paired transfer |
| done | output | 1 | Final cycle of an instruction |
| illegal | output | 1 | Strobed word rejected |

## Verification
The bench aims at the pointer arithmetic:
- If a design used the updated pointer for a post-increment load, or the old pointer for a pre-decrement store, the address would be off by one step.
- If a design applied the 4-byte step in paired mode, the pointers would drift, and later addresses would miss.

It drives odd pair fields in paired mode. A design that ignored the parity rule would write a register pair across the wrong boundary, or would move a pointer on a rejected word.

It strobes new words during the second cycle of a paired transfer. A design that accepted them would corrupt the transfer in flight. Such a design would show up as an extra write or a wrong address.

// File: rtl/fpmv_pkg.sv
package fpmv_pkg;
  localparam int WORD_W = 32;
  localparam int IDX_W  = 4;
  localparam int NREG   = 1 << IDX_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [IDX_W-1:0]  idx_t;

  typedef enum logic [2:0] {
    OP_NONE, OP_MOVE, OP_ST_IND, OP_LD_IND,
    OP_LD_POST, OP_ST_PRE, OP_LD_IDX, OP_ST_IDX
  } op_e;

  typedef struct packed {
    op_e  op;
    idx_t n;
    idx_t m;
    logic pair;
    logic legal;
  } dec_t;

  function automatic logic op_store(op_e op);
    return op inside {OP_ST_IND, OP_ST_PRE, OP_ST_IDX};
  endfunction

  function automatic logic op_load(op_e op);
    return op inside {OP_LD_IND, OP_LD_POST, OP_LD_IDX};
  endfunction

  function automatic logic op_mem(op_e op);
    return op_store(op) || op_load(op);
  endfunction

  function automatic logic op_writes_fr(op_e op);
    return op_load(op) || (op == OP_MOVE);
  endfunction

  function automatic logic op_reads_fr(op_e op);
    return op_store(op) || (op == OP_MOVE);
  endfunction

  function automatic logic op_adjusts(op_e op);
    return op inside {OP_LD_POST, OP_ST_PRE};
  endfunction

  function automatic word_t step_of(logic pair);
    return pair ? word_t'(8) : word_t'(4);
  endfunction

  // general register that supplies the address
  function automatic idx_t base_sel(dec_t d);
    return op_store(d.op) ? d.n : d.m;
  endfunction

  function automatic word_t first_addr(op_e op, word_t base, word_t r0, logic pair);
    case (op)
      OP_ST_PRE:           return base - step_of(pair);
      OP_LD_IDX, OP_ST_IDX: return base + r0;
      default:             return base;
    endcase
  endfunction

  function automatic word_t base_after(op_e op, word_t base, logic pair);
    case (op)
      OP_LD_POST: return base + step_of(pair);
      OP_ST_PRE:  return base - step_of(pair);
      default:    return base;
    endcase
  endfunction

  function automatic dec_t decode_word(logic [15:0] w, logic pair);
    dec_t d;
    d.n    = w[11:8];
    d.m    = w[7:4];
    d.pair = pair;
    d.op   = OP_NONE;
    if (w[15:12] == 4'hF) begin
      case (w[3:0])
        4'hC: d.op = OP_MOVE;
        4'hA: d.op = OP_ST_IND;
        4'h8: d.op = OP_LD_IND;
        4'h9: d.op = OP_LD_POST;
        4'hB: d.op = OP_ST_PRE;
        4'h6: d.op = OP_LD_IDX;
        4'h7: d.op = OP_ST_IDX;
        default: d.op = OP_NONE;
      endcase
    end
    d.legal = (d.op != OP_NONE) &&
              !(pair && ((op_writes_fr(d.op) && d.n[0]) ||
                         (op_reads_fr(d.op)  && d.m[0])));
    return d;
  endfunction
endpackage

// File: rtl/fpmv_decode.sv
module fpmv_decode
  import fpmv_pkg::*;
(
  input  logic [15:0] instr,
  input  logic        pair_mode,
  output dec_t        dec
);
  assign dec = decode_word(instr, pair_mode);
endmodule

// File: rtl/fpmv_regfile.sv
module fpmv_regfile #(
  parameter int          N        = 16,
  parameter int          W        = 32,
  parameter int          IW       = 4,
  parameter int          NRD      = 1,
  parameter logic [W-1:0] RST_BASE = '0,
  parameter logic [W-1:0] RST_STEP = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [IW-1:0]           waddr,
  input  logic [W-1:0]            wdata,
  input  logic [NRD-1:0][IW-1:0]  raddr,
  output logic [NRD-1:0][W-1:0]   rdata
);
  logic [W-1:0] q [N];

  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q[i] <= RST_BASE + W'(i) * RST_STEP;
      else if (we && waddr == IW'(i))      q[i] <= wdata;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata[r] = q[raddr[r]];
  end
endmodule

// File: rtl/fpmv_seq.sv
module fpmv_seq
  import fpmv_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  accept,
  input  dec_t  dec,
  input  word_t addr_now,
  output logic  ph2,
  output dec_t  held,
  output word_t held_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph2       <= 1'b0;
      held      <= '0;
      held_addr <= '0;
    end else begin
      ph2 <= accept && dec.pair;
      if (accept) begin
        held      <= dec;
        held_addr <= addr_now;
      end
    end
  end
endmodule

// File: rtl/fpmv_unit.sv
module fpmv_unit
  import fpmv_pkg::*;
#(
  parameter logic [31:0] GR_BASE = 32'h0000_1000,
  parameter logic [31:0] GR_STEP = 32'h0000_0100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        instr_vld,
  input  logic [15:0] instr,
  input  logic        pair_mode,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic        mem_we,
  input  logic [31:0] mem_rdata,
  output logic        busy,
  output logic        done,
  output logic        illegal
);
  dec_t  dec, held, slot;
  logic  ph2, start, accept, exec, slot_mem;
  word_t held_addr, addr_first, addr_now, gr_base, gr_r0, fr_rd;
  idx_t  fr_ridx, fr_widx;
  logic  gr_we, fr_we;
  word_t gr_wdata, fr_wdata;
  logic [1:0][IDX_W-1:0]  gr_ra;
  logic [1:0][WORD_W-1:0] gr_rd;
  logic [0:0][IDX_W-1:0]  fr_ra;
  logic [0:0][WORD_W-1:0] fr_rdv;

  fpmv_decode u_dec (.instr(instr), .pair_mode(pair_mode), .dec(dec));

  // named events for the checker
  assign start    = instr_vld && !ph2;
  assign accept   = start && dec.legal;
  assign slot     = ph2 ? held : dec;
  assign exec     = (start || ph2) && slot.legal;
  assign slot_mem = exec && op_mem(slot.op);

  // general registers: port 0 = address base, port 1 = R0
  assign gr_ra[0] = base_sel(dec);
  assign gr_ra[1] = '0;
  assign gr_base  = gr_rd[0];
  assign gr_r0    = gr_rd[1];
  assign gr_we    = accept && op_adjusts(dec.op);
  assign gr_wdata = base_after(dec.op, gr_base, dec.pair);

  fpmv_regfile #(
    .N(NREG), .W(WORD_W), .IW(IDX_W), .NRD(2),
    .RST_BASE(GR_BASE), .RST_STEP(GR_STEP)
  ) u_gr (
    .clk(clk), .rst_n(rst_n), .we(gr_we), .waddr(base_sel(dec)),
    .wdata(gr_wdata), .raddr(gr_ra), .rdata(gr_rd)
  );

  assign addr_first = first_addr(dec.op, gr_base, gr_r0, dec.pair);
  assign addr_now   = ph2 ? held_addr + word_t'(4) : addr_first;

  fpmv_seq u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .dec(dec),
    .addr_now(addr_now), .ph2(ph2), .held(held), .held_addr(held_addr)
  );

  // floating-point registers: second cycle selects the odd half
  assign fr_ridx  = {slot.m[IDX_W-1:1], slot.m[0] | ph2};
  assign fr_widx  = {slot.n[IDX_W-1:1], slot.n[0] | ph2};
  assign fr_ra[0] = fr_ridx;
  assign fr_rd    = fr_rdv[0];
  assign fr_we    = exec && op_writes_fr(slot.op);
  assign fr_wdata = op_load(slot.op) ? mem_rdata : fr_rd;

  fpmv_regfile #(
    .N(NREG), .W(WORD_W), .IW(IDX_W), .NRD(1),
    .RST_BASE('0), .RST_STEP('0)
  ) u_fr (
    .clk(clk), .rst_n(rst_n), .we(fr_we), .waddr(fr_widx),
    .wdata(fr_wdata), .raddr(fr_ra), .rdata(fr_rdv)
  );

  assign mem_we    = exec && op_store(slot.op);
  assign mem_addr  = slot_mem ? addr_now : '0;
  assign mem_wdata = mem_we ? fr_rd : '0;
  assign done      = exec && (ph2 || !slot.pair);
  assign busy      = ph2;
  assign illegal   = start && !dec.legal;
endmodule

// File: rtl/fpmv_chk.sv
module fpmv_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        illegal,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic        slot_mem,
  input logic        accept
);
  // R12
  illegal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!done && !mem_we && !busy));
  // R9
  pair_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  // R9
  pair_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> done);
  // R9
  pair_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && slot_mem) |-> (mem_addr == $past(mem_addr) + 32'd4));
  // R5
  pair_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(mem_we)) |-> mem_we);
  // R11
  busy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(accept));
  // R10
  illegal_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> !busy);
endmodule

bind fpmv_unit fpmv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .illegal(illegal),
  .mem_we(mem_we), .mem_addr(mem_addr), .slot_mem(slot_mem), .accept(accept)
);

// File: tb/sim_fpmv_unit.sv
module sim_fpmv_unit;
  localparam logic [31:0] GRB = 32'h0000_1000;
  localparam logic [31:0] GRS = 32'h0000_0100;
  localparam int MW = 1024;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, instr_vld, pair_mode, mem_we, busy, done, illegal;
  logic [15:0] instr;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  fpmv_unit #(.GR_BASE(GRB), .GR_STEP(GRS)) u0 (
    .clk(clk), .rst_n(rst_n), .instr_vld(instr_vld), .instr(instr),
    .pair_mode(pair_mode), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .illegal(illegal)
  );

  logic [31:0] dmem [MW];
  assign mem_rdata = dmem[mem_addr[11:2]];
  always @(posedge clk) if (mem_we) dmem[mem_addr[11:2]] <= mem_wdata;

  // reference state
  logic [31:0] rg [16];
  logic [31:0] rf [16];
  logic [31:0] rm [MW];
  bit          rph;
  int          hk;
  logic [3:0]  hn, hm;
  logic [31:0] ha;
  int nchk = 0, nbad = 0;
  bit finished = 0;
  string tag_ovr = "";

  function automatic logic [31:0] fill(int i);
    return 32'h5A00_0000 ^ (i * 32'h0001_0203);
  endfunction

  // 0 move,1 st [Rn],2 ld [Rm],3 ld post,4 st pre,5 ld idx,6 st idx,-1 none
  function automatic int kind_of(logic [15:0] w);
    if (w[15:12] != 4'b1111) return -1;
    case (w[3:0])
      4'b1100: return 0;
      4'b1010: return 1;
      4'b1000: return 2;
      4'b1001: return 3;
      4'b1011: return 4;
      4'b0110: return 5;
      4'b0111: return 6;
      default: return -1;
    endcase
  endfunction

  function automatic string tag_of(int k);
    case (k)
      0: return "R3";
      1: return "R5";
      2: return "R4";
      3: return "R6";
      4: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cycle(logic [15:0] w, bit v, bit p);
    int k; bit act, second, bad, e_busy, e_done, e_ill, e_we, nph;
    logic [3:0] n, m; logic [31:0] a, e_addr, e_wd, stp; string t;
    @(negedge clk);
    instr_vld = v; instr = w; pair_mode = p;
    #1;
    act = 0; second = 0; e_busy = 0; e_done = 0; e_ill = 0; e_we = 0;
    e_addr = 0; e_wd = 0; nph = 0; k = -1; n = 0; m = 0; a = 0; t = "R12";
    stp = p ? 32'd8 : 32'd4;
    if (rph) begin
      k = hk; second = 1; n = hn | 4'd1; m = hm | 4'd1; a = ha + 32'd4;
      e_busy = 1; e_done = 1; act = 1; t = v ? "R11" : "R9";
    end else if (v) begin
      k = kind_of(w); n = w[11:8]; m = w[7:4];
      bad = (k < 0) || (p && ((((k == 0) || (k == 2) || (k == 3) || (k == 5)) && n[0]) ||
                              (((k == 0) || (k == 1) || (k == 4) || (k == 6)) && m[0])));
      if (bad) begin
        e_ill = 1; t = (k < 0) ? "R2" : "R10";
      end else begin
        act = 1; t = p ? "R9" : tag_of(k);
        case (k)
          1: a = rg[n];
          2, 3: a = rg[m];
          4: a = rg[n] - stp;
          5: a = rg[0] + rg[m];
          6: a = rg[0] + rg[n];
          default: a = 0;
        endcase
        e_done = !p; nph = p; hk = k; hn = n; hm = m; ha = a;
      end
    end
    if (act && k != 0) e_addr = a;
    if (act && (k == 1 || k == 4 || k == 6)) begin e_we = 1; e_wd = rf[m]; end
    if (tag_ovr != "") t = tag_ovr;
    chk(t, "busy", {31'd0, busy}, {31'd0, e_busy});
    chk(t, "done", {31'd0, done}, {31'd0, e_done});
    chk(t, "illegal", {31'd0, illegal}, {31'd0, e_ill});
    chk(t, "mem_we", {31'd0, mem_we}, {31'd0, e_we});
    chk(t, "mem_addr", mem_addr, e_addr);
    if (e_we) chk(t, "mem_wdata", mem_wdata, e_wd);
    if (act) begin
      case (k)
        0: rf[n] = rf[m];
        2, 3, 5: rf[n] = rm[a[11:2]];
        default: rm[a[11:2]] = rf[m];
      endcase
      if (!second && k == 3) rg[m] = rg[m] + stp;
      if (!second && k == 4) rg[n] = rg[n] - stp;
    end
    rph = nph;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nbad++;
      $display("FAIL run: watchdog got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [3:0] codes [7];
    codes = '{4'hC, 4'hA, 4'h8, 4'h9, 4'hB, 4'h6, 4'h7};
    void'($urandom(32'd4242));
    for (int i = 0; i < MW; i++) begin dmem[i] = fill(i); rm[i] = fill(i); end
    for (int i = 0; i < 16; i++) begin rg[i] = GRB + i * GRS; rf[i] = 0; end
    rph = 0;
    rst_n = 0; instr_vld = 0; instr = 0; pair_mode = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1: idle after reset, then general register reset values via store addresses
    tag_ovr = "R1";
    cycle(16'h0000, 0, 0);
    for (int i = 0; i < 16; i++) cycle({4'hF, i[3:0], 4'h0, 4'hA}, 1, 0);
    tag_ovr = "";
    // R4 then R5: load FR2 from [R3], store it to [R5]
    cycle(16'hF238, 1, 0);
    cycle(16'hF52A, 1, 0);
    // R3 move FR2 -> FR7, store FR7
    cycle(16'hF72C, 1, 0);
    cycle(16'hF17A, 1, 0);
    // R2: foreign words
    cycle(16'h1234, 1, 0);
    cycle(16'hF00F, 1, 0);
    // R10: odd destination load, odd source store, odd move in paired mode
    cycle(16'hF138, 1, 1);
    cycle(16'hF21A, 1, 1);
    cycle(16'hF21C, 1, 1);
    // R10 state untouched: re-read pointer R3 and R2 by single indirect stores
    cycle(16'hF30A, 1, 0);
    cycle(16'hF20A, 1, 0);
    // R6/R7 paired: post-inc load into DR pair 4/5, pre-dec store from pair 4/5
    cycle(16'hF469, 1, 1);
    cycle(16'h0000, 0, 1);
    cycle(16'hF64B, 1, 1);
    cycle(16'hF00C, 1, 0);
    // R11: strobes during second cycle are ignored
    cycle(16'hF248, 1, 1);
    cycle(16'hF12A, 1, 0);
    // R8 indexed single load and store
    cycle(16'hF836, 1, 0);
    cycle(16'hF987, 1, 0);
    cycle(16'hF90A, 1, 0);
    // random mix
    for (int i = 0; i < 6000; i++) begin
      int r; logic [15:0] w;
      r = int'($urandom % 100);
      if (r < 8) w = 16'($urandom);
      else w = {4'hF, 4'($urandom), 4'($urandom), codes[$urandom % 7]};
      cycle(w, r < 90, 1'($urandom));
    end
    cycle(16'h0000, 0, 0);
    cycle(16'h0000, 0, 0);
    finished = 1;
    summary();
    $finish;
  end
endmodule